// File: doc/BRIEF.md
# Latched Interval Timer

This block holds two 16-bit down-counters behind a small byte-wide register port. The primary counter reloads from a 17-bit period latch every time it runs out, and in continuous mode it raises a one-cycle interrupt request at each reload. The secondary counter has no latch of its own and no interrupt: it always wraps with a full 65536-tick period. Software reaches both counters, the primary latch and a mode byte through eight byte addresses, and reads always return the live counter value.

The timer tick is supplied from outside as an enable (`tick_en`), which lets the system produce the intended rate, an input clock of 4.7 MHz divided by 6, with its own prescaler. Interrupt flag storage and masking sit outside this block; it only emits the pulse.

Top module: `ivtimer`

## Requirements
- R1: After synchronous reset both counters read 0xFFFF, the primary latch holds 0x10000 (its two readable bytes read 0x00), the mode byte reads 0x00 and `irq` is low.
- R2: A write to a counter's low-byte address loads {that counter's current high byte, written byte}; a write to its high-byte address loads {written byte, current low byte}. Addresses: 0 primary low, 1 primary high, 4 secondary low, 5 secondary high.
- R3: A write to address 2 (latch bits 7:0) or address 3 (latch bits 15:8) replaces only that byte, clears latch bit 16, and leaves the counter value untouched; the new latch is used at the next reload.
- R4: Each clock cycle with `tick_en` high and no counter write decrements the counter by one; without `tick_en` the counter holds.
- R5: A tick that finds the primary counter at zero loads latch minus one (zero when the latch is zero), so a loaded value V reaches its first reload on tick V+1 and each later period lasts latch ticks.
- R6: `irq` is high for exactly the one cycle after a reloading tick, and only when mode byte bits 7:6 equal 01 at that tick; the other mode bits are ignored.
- R7: With mode bits 7:6 at 00, 10 or 11 the counter still reloads but `irq` stays low; leaving mode 01 before a reload suppresses that reload's pulse.
- R8: The secondary counter wraps from zero to 0xFFFF (65536-tick period), never causes `irq`, and is not affected by latch writes.
- R9: `rd_data` follows `addr` combinationally: 0/1 primary counter low/high, 2/3 latch bits 7:0 / 15:8, 4/5 secondary counter low/high, 6 the mode byte, 7 reads 0x00 and ignores writes.
- R10: When a counter write and a tick fall in the same cycle, the write wins: no decrement, no reload and no pulse in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer tick enable, one cycle per tick |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte for `addr` |
| irq | output | 1 | One-cycle interrupt request at a reload in continuous mode |

## Verification
On every cycle the embedded properties check the single-step decrement, the reload value taken from the latch, the byte-merge on counter writes, that latch bit 16 drops after any latch write, that only one register strobe fires, that the mode byte and latch hold without a write, and that every pulse follows a reload made in continuous mode. Period lengths across several reloads, pulse counts per mode, suppression after leaving continuous mode, a zero latch, secondary-counter wrap and write-versus-tick collisions need whole sequences, so only the directed bench scenarios show them.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_PRI_LO  = 3'd0,
        RA_PRI_HI  = 3'd1,
        RA_PER_LO  = 3'd2,
        RA_PER_HI  = 3'd3,
        RA_SEC_LO  = 3'd4,
        RA_SEC_HI  = 3'd5,
        RA_MODE    = 3'd6,
        RA_SPARE   = 3'd7
    } reg_addr_e;

    // Mode byte field that selects the interrupt behaviour
    localparam int MODE_MSB = 7;
    localparam int MODE_LSB = 6;
    localparam logic [1:0] MODE_CONT = 2'b01;

    typedef struct packed {
        logic pri_lo;
        logic pri_hi;
        logic per_lo;
        logic per_hi;
        logic sec_lo;
        logic sec_hi;
        logic mode;
    } wr_strb_t;

    function automatic logic is_cont(input logic [BYTE_W-1:0] mode_byte);
        return mode_byte[MODE_MSB:MODE_LSB] == MODE_CONT;
    endfunction

endpackage

// File: rtl/ivt_regbank.sv
module ivt_regbank
    import ivt_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output wr_strb_t      strb,
    output logic [DW-1:0] mode_o
);

    logic [DW-1:0] mode_q;

    always_comb begin
        strb = '0;
        if (wr_en) begin
            case (reg_addr_e'(addr))
                RA_PRI_LO: strb.pri_lo = 1'b1;
                RA_PRI_HI: strb.pri_hi = 1'b1;
                RA_PER_LO: strb.per_lo = 1'b1;
                RA_PER_HI: strb.per_hi = 1'b1;
                RA_SEC_LO: strb.sec_lo = 1'b1;
                RA_SEC_HI: strb.sec_hi = 1'b1;
                RA_MODE:   strb.mode   = 1'b1;
                default:   strb        = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (strb.mode) begin
            mode_q <= wr_data;
        end
    end

    assign mode_o = mode_q;

    AST_STRB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strb)); // R9

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == AW'(RA_MODE)) |=> $stable(mode_q)); // R7

endmodule

// File: rtl/ivt_latch.sv
module ivt_latch #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic [2*BYTE_W:0]   latch_o,
    output logic [2*BYTE_W-1:0] reload_o
);

    localparam int CNT_W = 2 * BYTE_W;
    localparam int LAT_W = CNT_W + 1;
    localparam logic [LAT_W-1:0] LAT_RST = LAT_W'(1) << CNT_W;

    logic [LAT_W-1:0] latch_q;
    logic [LAT_W-1:0] lat_m1;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= LAT_RST;
        end else if (wr_lo) begin
            latch_q <= {1'b0, latch_q[CNT_W-1:BYTE_W], wr_data};
        end else if (wr_hi) begin
            latch_q <= {1'b0, wr_data, latch_q[BYTE_W-1:0]};
        end
    end

    // Period of N ticks means counting N-1 down to 0; a zero latch pins the reload at 0
    assign lat_m1   = latch_q - LAT_W'(1);
    assign reload_o = (latch_q == '0) ? '0 : lat_m1[CNT_W-1:0];
    assign latch_o  = latch_q;

    AST_LATCH_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_lo || wr_hi) |=> !latch_q[CNT_W]); // R3

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_lo || wr_hi) |=> $stable(latch_q)); // R3

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_en,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic [2*BYTE_W-1:0] reload_val,
    output logic [2*BYTE_W-1:0] count_o,
    output logic                wrap_o
);

    localparam int CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0] count_q;
    logic             step;
    logic             at_zero;

    // A software write in the same cycle takes precedence over the tick
    assign step    = tick_en && !wr_lo && !wr_hi;
    assign at_zero = (count_q == '0);
    assign wrap_o  = step && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '1;
        end else if (wr_lo) begin
            count_q <= {count_q[CNT_W-1:BYTE_W], wr_data};
        end else if (wr_hi) begin
            count_q <= {wr_data, count_q[BYTE_W-1:0]};
        end else if (step) begin
            count_q <= at_zero ? reload_val : count_q - CNT_W'(1);
        end
    end

    assign count_o = count_q;

    AST_DEC_ONE: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !wr_lo && !wr_hi && count_q != '0) |=> count_q == $past(count_q) - CNT_W'(1)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !wr_lo && !wr_hi) |=> $stable(count_q)); // R4

    AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !wr_lo && !wr_hi && count_q == '0) |=> count_q == $past(reload_val)); // R5

    AST_LO_MERGE: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> count_q[CNT_W-1:BYTE_W] == $past(count_q[CNT_W-1:BYTE_W])); // R2

    AST_HI_MERGE: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> count_q[BYTE_W-1:0] == $past(count_q[BYTE_W-1:0])); // R2

endmodule

// File: rtl/ivtimer.sv
module ivtimer
    import ivt_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          irq
);

    localparam int CNT_W = 2 * DW;
    localparam int LAT_W = CNT_W + 1;

    wr_strb_t         strb;
    logic [DW-1:0]    mode_byte;
    logic [LAT_W-1:0] latch_val;
    logic [CNT_W-1:0] reload_pri;
    logic [CNT_W-1:0] count_pri;
    logic [CNT_W-1:0] count_sec;
    logic             wrap_pri;
    logic             wrap_sec;
    logic             irq_q;

    ivt_regbank #(.DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .strb    (strb),
        .mode_o  (mode_byte)
    );

    ivt_latch #(.BYTE_W(DW)) u_period (
        .clk      (clk),
        .rst      (rst),
        .wr_lo    (strb.per_lo),
        .wr_hi    (strb.per_hi),
        .wr_data  (wr_data),
        .latch_o  (latch_val),
        .reload_o (reload_pri)
    );

    ivt_counter #(.BYTE_W(DW)) u_pri (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .wr_lo      (strb.pri_lo),
        .wr_hi      (strb.pri_hi),
        .wr_data    (wr_data),
        .reload_val (reload_pri),
        .count_o    (count_pri),
        .wrap_o     (wrap_pri)
    );

    // Secondary counter: fixed full-range period, wraps from zero to all ones
    ivt_counter #(.BYTE_W(DW)) u_sec (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .wr_lo      (strb.sec_lo),
        .wr_hi      (strb.sec_hi),
        .wr_data    (wr_data),
        .reload_val ({CNT_W{1'b1}}),
        .count_o    (count_sec),
        .wrap_o     (wrap_sec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= wrap_pri && is_cont(mode_byte);
        end
    end

    assign irq = irq_q;

    always_comb begin
        case (reg_addr_e'(addr))
            RA_PRI_LO: rd_data = count_pri[DW-1:0];
            RA_PRI_HI: rd_data = count_pri[CNT_W-1:DW];
            RA_PER_LO: rd_data = latch_val[DW-1:0];
            RA_PER_HI: rd_data = latch_val[CNT_W-1:DW];
            RA_SEC_LO: rd_data = count_sec[DW-1:0];
            RA_SEC_HI: rd_data = count_sec[CNT_W-1:DW];
            RA_MODE:   rd_data = mode_byte;
            default:   rd_data = '0;
        endcase
    end

    AST_IRQ_CONT_ONLY: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(mode_byte[MODE_MSB:MODE_LSB]) == MODE_CONT); // R6

    AST_IRQ_AFTER_RELOAD: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(tick_en) && $past(count_pri) == '0 && count_pri == $past(reload_pri))); // R5

    AST_SEC_WRAP_FULL: assert property (@(posedge clk) disable iff (rst)
        wrap_sec |=> count_sec == {CNT_W{1'b1}}); // R8

endmodule

// File: tb/sim_ivtimer.sv
`timescale 1ns/1ps
module sim_ivtimer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;
    int irq_cnt  = 0;
    int run_len  = 0;
    int max_run  = 0;

    always #2.5 clk = ~clk;

    ivtimer u0 (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq     (irq)
    );

    // Pulse monitor: samples 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (!rst && irq) begin
            irq_cnt++;
            run_len++;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_tick(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; tick_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic rd8(input logic [2:0] a, output int v);
        addr = a;
        #0.5;
        v = int'(rd_data);
    endtask

    task automatic rd16(input logic [2:0] lo_a, output int v);
        int lo, hi;
        rd8(lo_a, lo);
        rd8(lo_a + 3'd1, hi);
        v = (hi << 8) | lo;
    endtask

    task automatic set_pri(input int v);
        wr(3'd0, v[7:0]);
        wr(3'd1, v[15:8]);
    endtask

    task automatic t_reset();
        int v;
        rd16(3'd0, v); check("R1 primary count", v, 16'hFFFF);
        rd16(3'd4, v); check("R1 secondary count", v, 16'hFFFF);
        rd16(3'd2, v); check("R1 latch bytes", v, 0);
        rd8(3'd6, v);  check("R1 mode byte", v, 0);
        check("R1 irq low", int'(irq), 0);
        wr(3'd7, 8'hA5);
        rd8(3'd7, v);  check("R9 spare address reads zero", v, 0);
    endtask

    task automatic t_byte_writes();
        int v;
        wr(3'd0, 8'h34);
        rd16(3'd0, v); check("R2 low write keeps high", v, 16'hFF34);
        wr(3'd1, 8'h12);
        rd16(3'd0, v); check("R2 high write keeps low", v, 16'h1234);
        wr(3'd4, 8'h00);
        rd16(3'd4, v); check("R2 secondary low write", v, 16'hFF00);
        wr(3'd5, 8'h01);
        rd16(3'd4, v); check("R2 secondary high write", v, 16'h0100);
    endtask

    task automatic t_decrement();
        int v;
        irq_cnt = 0;
        ticks(5);
        rd16(3'd0, v); check("R4 primary after 5 ticks", v, 16'h122F);
        rd16(3'd4, v); check("R4 secondary after 5 ticks", v, 16'h00FB);
        repeat (3) @(negedge clk);
        rd16(3'd0, v); check("R4 hold without tick", v, 16'h122F);
        check("R7 no irq in mode 00", irq_cnt, 0);
    endtask

    task automatic t_reload_cont();
        int v;
        wr(3'd2, 8'h05);
        wr(3'd3, 8'h00);
        rd16(3'd2, v); check("R3 latch readback", v, 16'h0005);
        rd16(3'd0, v); check("R3 latch write leaves counter", v, 16'h122F);
        rd16(3'd4, v); check("R8 latch write leaves secondary", v, 16'h00FB);
        wr(3'd6, 8'h40);
        rd8(3'd6, v);  check("R9 mode readback", v, 8'h40);
        set_pri(3);
        irq_cnt = 0; max_run = 0;
        ticks(3);
        rd16(3'd0, v); check("R5 counted down to zero", v, 0);
        check("R5 no reload before tick V+1", irq_cnt, 0);
        ticks(1);
        rd16(3'd0, v); check("R5 first reload to latch-1", v, 4);
        check("R6 pulse at first reload", irq_cnt, 1);
        ticks(4);
        check("R5 no pulse inside period", irq_cnt, 1);
        ticks(1);
        check("R5 second period equals latch", irq_cnt, 2);
        rd16(3'd0, v); check("R5 second reload value", v, 4);
        check("R6 pulse width one cycle", max_run, 1);
    endtask

    task automatic t_modes();
        int v;
        logic [7:0] modes [4] = '{8'h00, 8'h80, 8'hC0, 8'h3F};
        for (int i = 0; i < 4; i++) begin
            wr(3'd6, modes[i]);
            set_pri(0);
            irq_cnt = 0;
            ticks(1);
            repeat (2) @(negedge clk);
            rd16(3'd0, v); check("R7 reload still happens", v, 4);
            check("R7 no pulse outside mode 01", irq_cnt, 0);
        end
        wr(3'd6, 8'h7F);
        set_pri(0);
        irq_cnt = 0;
        ticks(1);
        check("R6 other mode bits ignored", irq_cnt, 1);
        wr(3'd6, 8'h40);
        set_pri(1);
        ticks(1);
        wr(3'd6, 8'h00);
        irq_cnt = 0;
        ticks(1);
        repeat (2) @(negedge clk);
        rd16(3'd0, v); check("R7 reload after leaving mode 01", v, 4);
        check("R7 pulse suppressed after leaving", irq_cnt, 0);
    endtask

    task automatic t_latch_zero();
        int v;
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h00);
        wr(3'd6, 8'h40);
        set_pri(0);
        irq_cnt = 0;
        ticks(3);
        rd16(3'd0, v); check("R5 zero latch reloads zero", v, 0);
        check("R5 zero latch pulses every tick", irq_cnt, 3);
    endtask

    task automatic t_write_vs_tick();
        int v;
        wr(3'd2, 8'h05);
        set_pri(16'h0010);
        wr_tick(3'd0, 8'h20);
        rd16(3'd0, v); check("R10 write beats tick", v, 16'h0020);
        set_pri(0);
        irq_cnt = 0;
        wr_tick(3'd1, 8'h00);
        repeat (2) @(negedge clk);
        rd16(3'd0, v); check("R10 no reload on collision", v, 0);
        check("R10 no pulse on collision", irq_cnt, 0);
    endtask

    task automatic t_secondary_wrap();
        int v;
        wr(3'd6, 8'h00);
        wr(3'd4, 8'h00);
        wr(3'd5, 8'h00);
        rd16(3'd4, v); check("R8 secondary at zero", v, 0);
        irq_cnt = 0;
        ticks(1);
        rd16(3'd4, v); check("R8 secondary wraps to FFFF", v, 16'hFFFF);
        wr(3'd3, 8'h00);
        ticks(1);
        rd16(3'd4, v); check("R8 secondary keeps full period", v, 16'hFFFE);
        wr(3'd6, 8'h40);
        wr(3'd4, 8'h00);
        wr(3'd5, 8'h00);
        wr(3'd0, 8'h50);
        irq_cnt = 0;
        ticks(1);
        repeat (2) @(negedge clk);
        check("R8 secondary wrap gives no irq", irq_cnt, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_byte_writes();
        t_decrement();
        t_reload_cont();
        t_modes();
        t_latch_zero();
        t_write_vs_tick();
        t_secondary_wrap();
        repeat (2) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule